// File: doc/BRIEF.md
# Cascadable Four-Channel Down-Counting Timer Group

The block holds four down-counting timers that share one clock prescaler and one group control word. Each timer has a writable base count and a live current count, and it drives an interrupt line of its own. A timer that reaches zero on a prescaled tick reloads from its base count. It also flips a toggle flag and raises its interrupt for one cycle, so a running timer keeps firing at a fixed period until its stop bit is set.

Two adjacent timers can be joined into one long counter. In a joined pair the lower-numbered timer is the low half and has its full word width available. The higher-numbered timer is the high half: it steps only when the low half wraps, it owns the pair's stop bit and it owns the pair's interrupt. A rollover flag for each pair selects between two behaviours after the pair expires. Either the pair keeps running periodically, or it sets its own stop bit and halts after a single expiry.

Software reaches every register through a single-cycle write strobe and a combinational read port. No pin carries a data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `tmr_quad`

## Requirements
- R1: After reset every base-count register reads 0x8000_0000, so all timers start stopped. Every current count reads 0, the control word reads 0 and all interrupt lines are low.
- R2: Control bits 9:8 select the prescaler. The code 0 gives one tick every 8 clocks, 1 gives one every 16, 2 gives one every 32 and 3 gives one every 64. Ticks never occur on two consecutive clocks.
- R3: A running stand-alone timer steps down by one on each tick. On a tick that finds the count at zero, it reloads base bits 30:0 instead of stepping. Its interrupt period is therefore (base+1) ticks.
- R4: Bit 31 of a base-count register is its stop bit. While that bit is set, the timer's count holds and the timer raises no interrupt.
- R5: Bit 31 of a stand-alone timer's current count is a toggle flag that flips on every expiry. Bits 30:0 hold the remaining count.
- R6: Writing a base-count register also loads the count. Writing a current-count register loads the count with the written value. A written value of zero makes the timer expire on the next tick.
- R7: Control bit p (p = 0, 1, 2) joins timer p as the low half with timer p+1 as the high half. Where two enabled pairs would share a timer, the lower pair wins and the other pair is ignored. A joined pair fires every (high base+1)×(low base+1) ticks on the high timer's line only, and the low timer's line stays low.
- R8: For the low half of a joined pair, base and current count are full 32-bit counts with no stop or toggle bit. The low half is stopped by the high half's stop bit.
- R9: Control bit 24+p is the rollover flag of pair p. When the flag is set, the pair runs periodically. When it is clear, the pair's expiry sets the high timer's stop bit and the pair halts.
- R10: Register map: addresses 0 to 3 hold the base counts of timers 0 to 3, addresses 4 to 7 hold their current counts and address 8 holds the control word. Control reads back only bits 26:24, 9:8 and 2:0, and every other address reads 0.
- R11: An interrupt goes high in the clock after the expiring tick and stays high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe; the write takes effect at the next rising edge |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data at `addr` |
| irq | output | 4 | One-cycle interrupt pulse per timer |

## Verification
The hardest states to reach are the ones where the control word conflicts with itself or with the pairing. One case is two overlapping pair enables, where the bench must show that the middle timer serves only the lower pair while the upper timer of the ignored pair runs alone. The other is the one-shot halt, where a pair's own expiry writes a stop bit that software never touched. Each scenario starts from reset and writes the control word and the base counts in an order that keeps the high half stopped until the low half is loaded. The bench then times the spacing between interrupt pulses against the tick arithmetic and reads the base register back after the halt.

// File: rtl/tmr_quad_pkg.sv
package tmr_quad_pkg;
  // control word field positions (decoded by software, so fixed)
  localparam int CASC_LSB     = 0;
  localparam int DIV_LSB      = 8;
  localparam int ROVR_LSB     = 24;
  // log2 of the smallest prescale ratio
  localparam int PRE_BASE_LOG = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIVW     = 2,
  parameter int BASE_LOG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] sel,
  output logic            tick
);
  localparam int CW = BASE_LOG + (1 << DIVW) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  always_comb limit = CW'((32'd1 << (BASE_LOG + 32'(sel))) - 32'd1);

  // >= keeps the counter bounded when the ratio shrinks mid-count
  assign tick = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wide,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] base,
  output logic [W-1:0] cnt,
  output logic         tgl,
  output logic         expire
);
  function automatic logic [W-1:0] fit(input logic [W-1:0] v, input logic full);
    return full ? v : {1'b0, v[W-2:0]};
  endfunction

  assign expire = tick && !ld && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tgl <= 1'b0;
    end else if (ld) begin
      cnt <= fit(ld_val, wide);
    end else if (expire) begin
      cnt <= fit(base, wide);
      tgl <= ~tgl;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
  import tmr_quad_pkg::*;
#(
  parameter int NTMR   = 4,
  parameter int W      = 32,
  parameter int DIVW   = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rd_data,
  output logic [NTMR-1:0]   irq
);
  localparam int NPAIR     = NTMR - 1;
  localparam int CTRL_ADDR = 2 * NTMR;

  logic              pre_tick;
  logic [DIVW-1:0]   div_q;
  logic [NPAIR-1:0]  casc_q, rovr_q, pair_on;
  logic [W-1:0]      base_q [NTMR];
  logic [W-1:0]      cnt_w  [NTMR];
  logic [W-1:0]      ctrl_word;
  logic [NTMR-1:0]   tgl_w, expire_w, is_low, stop_w, run_w, zero_w;
  logic [NTMR-1:0]   tick_w, ld_w, halt_req, irq_d, irq_q;

  tmr_prescale #(.DIVW(DIVW), .BASE_LOG(PRE_BASE_LOG)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (div_q),
    .tick (pre_tick)
  );

  // lower pair wins when two enabled pairs share a timer
  always_comb begin
    logic prev;
    prev = 1'b0;
    for (int p = 0; p < NPAIR; p++) begin
      pair_on[p] = casc_q[p] && !prev;
      prev       = pair_on[p];
    end
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    if (i < NPAIR) begin : g_lo
      assign is_low[i] = pair_on[i];
      assign stop_w[i] = pair_on[i] ? base_q[i+1][W-1] : base_q[i][W-1];
    end else begin : g_nolo
      assign is_low[i] = 1'b0;
      assign stop_w[i] = base_q[i][W-1];
    end

    if (i > 0) begin : g_hi
      // high half steps on the low half's wrap
      assign tick_w[i]   = pair_on[i-1] ? (run_w[i-1] && zero_w[i-1] && !ld_w[i-1])
                                        : run_w[i];
      assign halt_req[i] = pair_on[i-1] && expire_w[i] && !rovr_q[i-1];
    end else begin : g_nohi
      assign tick_w[i]   = run_w[i];
      assign halt_req[i] = 1'b0;
    end

    assign run_w[i]  = pre_tick && !stop_w[i];
    assign zero_w[i] = (cnt_w[i] == '0);
    assign ld_w[i]   = wr_en && ((addr == ADDR_W'(i)) || (addr == ADDR_W'(NTMR + i)));
    assign irq_d[i]  = expire_w[i] && !is_low[i];

    tmr_chan #(.W(W)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_w[i]),
      .wide  (is_low[i]),
      .ld    (ld_w[i]),
      .ld_val(wdata),
      .base  (base_q[i]),
      .cnt   (cnt_w[i]),
      .tgl   (tgl_w[i]),
      .expire(expire_w[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTMR; i++) base_q[i] <= {1'b1, {(W-1){1'b0}}};
    end else begin
      for (int i = 0; i < NTMR; i++) begin
        if (wr_en && addr == ADDR_W'(i)) base_q[i]        <= wdata;
        else if (halt_req[i])            base_q[i][W-1]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      casc_q <= '0;
      rovr_q <= '0;
    end else if (wr_en && addr == ADDR_W'(CTRL_ADDR)) begin
      div_q  <= wdata[DIV_LSB +: DIVW];
      casc_q <= wdata[CASC_LSB +: NPAIR];
      rovr_q <= wdata[ROVR_LSB +: NPAIR];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
  assign irq = irq_q;

  always_comb begin
    ctrl_word                     = '0;
    ctrl_word[DIV_LSB +: DIVW]    = div_q;
    ctrl_word[CASC_LSB +: NPAIR]  = casc_q;
    ctrl_word[ROVR_LSB +: NPAIR]  = rovr_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NTMR; i++) begin
      if (addr == ADDR_W'(i)) rd_data = base_q[i];
      if (addr == ADDR_W'(NTMR + i))
        rd_data = is_low[i] ? cnt_w[i] : {tgl_w[i], cnt_w[i][W-2:0]};
    end
    if (addr == ADDR_W'(CTRL_ADDR)) rd_data = ctrl_word;
  end
endmodule

// File: rtl/tmr_quad_chk.sv
module tmr_quad_chk #(
  parameter int NTMR = 4,
  parameter int W    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [NTMR-1:0] irq,
  input logic            casc0,
  input logic            hi_stop,
  input logic [W-1:0]    hi_cnt,
  input logic            hi_tgl,
  input logic            pre_tick
);
  for (genvar i = 0; i < NTMR; i++) begin : g_pulse
    // R11
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);
  end

  // R7
  low_half_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> !$past(casc0));

  // R4
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_stop && !wr_en) |=> $stable(hi_cnt));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

  // R5
  toggle_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_tgl != $past(hi_tgl)) |-> irq[NTMR-1]);
endmodule

bind tmr_quad tmr_quad_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .irq     (irq),
  .casc0   (casc_q[0]),
  .hi_stop (base_q[3][31]),
  .hi_cnt  (cnt_w[3]),
  .hi_tgl  (tgl_w[3]),
  .pre_tick(pre_tick)
);

// File: tb/tmr_quad_bench.sv
module tmr_quad_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_quad u_tmr_quad (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  // counts negedges until irq[idx] is seen; -1 on timeout
  task automatic wait_irq(input int idx, input int limit, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (irq[idx]) break;
      if (n > limit) begin n = -1; break; end
    end
  endtask

  task automatic count_irq(input int idx, input int cycles, output int c);
    c = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (irq[idx]) c++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      rd(4'(i), d);     check("R1", "base reset", d, 32'h8000_0000);
      rd(4'(4 + i), d); check("R1", "count reset", d, 0);
    end
    rd(4'd8, d); check("R1", "ctrl reset", d, 0);
    check("R1", "irq reset", irq, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int c;
    do_reset();
    wr(4'd2, 32'h8000_0005);
    rd(4'd6, d); check("R6", "base write loads count", d, 5);
    count_irq(2, 200, c);
    rd(4'd6, d); check("R4", "stopped count holds", d, 5);
    check("R4", "stopped timer silent", c, 0);
  endtask

  task automatic t_period();
    int n;
    do_reset();
    wr(4'd3, 32'd3);
    wait_irq(3, 200, n);
    wait_irq(3, 200, n); check("R3", "period base 3 div 8", n, 32);
    @(negedge clk); check("R11", "irq one cycle", irq[3], 0);
    wr(4'd8, 32'h0000_0300);
    wait_irq(3, 1000, n);
    wait_irq(3, 1000, n); check("R2", "period div 64", n, 256);
    wr(4'd8, 32'h0000_0100);
    wait_irq(3, 1000, n);
    wait_irq(3, 1000, n); check("R2", "period div 16", n, 64);
  endtask

  task automatic t_toggle();
    logic [31:0] a, b;
    int n;
    do_reset();
    wr(4'd3, 32'd20);
    rd(4'd7, a);
    wait_irq(3, 400, n);
    rd(4'd7, b);
    check("R5", "toggle flips", b[31], !a[31]);
    check("R5", "count after reload", b[30:0], 20);
  endtask

  task automatic t_force();
    logic [31:0] d;
    int n;
    do_reset();
    wr(4'd1, 32'd1000);
    repeat (20) @(negedge clk);
    wr(4'd5, 32'd0);
    wait_irq(1, 20, n);
    check("R6", "zero write expires within a tick", (n > 0 && n <= 9), 1);
    rd(4'd5, d);
    check("R6", "reload after forced expiry", (d[30:0] <= 1000 && d[30:0] >= 999), 1);
  endtask

  task automatic t_cascade();
    int n, c;
    do_reset();
    wr(4'd8, 32'h0100_0001);
    wr(4'd0, 32'd1);
    wr(4'd1, 32'd2);
    wait_irq(1, 200, n);
    wait_irq(1, 200, n); check("R7", "pair period", n, 48);
    count_irq(0, 200, c); check("R7", "low half silent", c, 0);
    count_irq(1, 96, c);  check("R9", "rollover keeps pair periodic", c, 2);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    int n, c;
    do_reset();
    wr(4'd8, 32'h0000_0001);
    wr(4'd0, 32'd1);
    wr(4'd1, 32'd2);
    wait_irq(1, 100, n);
    check("R9", "one-shot fires", (n > 0), 1);
    rd(4'd1, d); check("R9", "high stop bit set", d, 32'h8000_0002);
    count_irq(1, 200, c); check("R9", "pair halted", c, 0);
  endtask

  task automatic t_overlap();
    logic [31:0] d;
    int n;
    do_reset();
    wr(4'd8, 32'h0300_0003);
    rd(4'd8, d); check("R10", "ctrl readback", d, 32'h0300_0003);
    wr(4'd2, 32'd1);
    wait_irq(2, 100, n);
    wait_irq(2, 100, n); check("R7", "ignored pair leaves timer 2 alone", n, 16);
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd0);
    wait_irq(1, 100, n);
    wait_irq(1, 100, n); check("R7", "lower pair active", n, 8);
  endtask

  task automatic t_wide();
    logic [31:0] d;
    do_reset();
    wr(4'd8, 32'h0000_0001);
    wr(4'd0, 32'h8000_0003);
    rd(4'd4, d); check("R8", "low half full width", d, 32'h8000_0003);
    repeat (50) @(negedge clk);
    rd(4'd4, d); check("R8", "low half stopped by high", d, 32'h8000_0003);
    wr(4'd8, 32'h0);
    wr(4'd0, 32'h8000_0003);
    rd(4'd4, d); check("R5", "stand-alone count masked", d, 32'h0000_0003);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    do_reset();
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, d); check("R10", "ctrl mask", d, 32'h0700_0307);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), d); check("R10", "unmapped read", d, 0);
    end
  endtask

  initial begin
    t_reset();
    t_stop();
    t_period();
    t_toggle();
    t_force();
    t_cascade();
    t_oneshot();
    t_overlap();
    t_wide();
    t_ctrl();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule